// File: doc/BRIEF.md
# Area Chip-Select Generator

This block drives eight active-low chip-select lines, one for each of eight equal areas of the external address space. When the part runs in an expanded operating mode and the bus marks an access to an external address, the area index is taken from the three address bits just above the area-size boundary. The matching select line is driven low for as long as the access lasts. Accesses that the bus flags as on-chip (ROM, RAM or internal registers) leave every select high. In single-chip modes every select stays high.

Each select line also has a pin output-enable. When that enable is 0 the pin floats, whatever the decoded level. The enables for areas 0 to 3 come from a 4-bit direction register. The enables for areas 4 to 7 come from a separate 4-bit select-control register. Both registers are written and read back through a small register port. At reset the control register clears. The direction register clears too, except that bit 0 sets when the on-chip-ROM strap is low, so the area 0 select drives from the start in that case.

Top module: `area_csel_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cs_n` is 8'hFF and `reg_rdata` is 4'h0 when the direction register reads 0.
- R2: With `mode_exp`=1, `bus_as`=1 and `bus_onchip`=0 sampled at a rising edge, `cs_n[i]` is 0 after that edge, where i = `bus_addr[23:21]`. All other bits are 1.
- R3: At no time is more than one bit of `cs_n` low.
- R4: An access sampled with `bus_onchip`=1 leaves `cs_n` at 8'hFF after that edge.
- R5: An access sampled with `mode_exp`=0 leaves `cs_n` at 8'hFF after that edge.
- R6: With `bus_as`=0 sampled, `cs_n` is 8'hFF after that edge, so a select deasserts one edge after the strobe ends.
- R7: A write with `reg_sel`=0 loads `reg_wdata` into the direction register, which is seen on `cs_oe[3:0]` after that edge. A bit value of 1 enables the pin.
- R8: A write with `reg_sel`=1 loads the select-control register, which is seen on `cs_oe[7:4]` after that edge. Reset clears all four of its bits.
- R9: Reset with `rom_en`=0 gives `cs_oe`=8'h01. Reset with `rom_en`=1 gives `cs_oe`=8'h00.
- R10: `reg_rdata` is registered. It shows the register chosen by `reg_sel` (0 for direction, 1 for control) as it stood before the most recent edge.
- R11: Bus accesses and edges without `reg_we` leave `cs_oe` unchanged, and a pin whose enable is 0 still has its `cs_n` level decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_exp | input | 1 | Strap: 1 selects an expanded (external bus) mode |
| rom_en | input | 1 | Strap: 1 when on-chip ROM is enabled |
| bus_addr | input | 24 | Bus address |
| bus_as | input | 1 | Address-valid strobe for the current bus cycle |
| bus_onchip | input | 1 | 1 when the access targets on-chip ROM, RAM or registers |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 direction, 1 select-control |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Registered read data |
| cs_n | output | 8 | Active-low chip selects, one per area |
| cs_oe | output | 8 | Per-pin output enables for the chip selects |

## Verification
External accesses go to every one of the eight areas with different low-address fillers. This shows that only the three area bits choose the select line and that exactly one line goes low. The same addresses are then issued with the on-chip flag set, with the mode strap cleared, and with the strobe dropped. Each of these patterns must give an all-high result, which separates the three suppressing conditions from one another. Register writes of alternating and inverse patterns, plus resets under both ROM strap values, separate the two enable sources and their reset defaults. Accesses issued with all enables cleared show that decoding does not depend on the enables.

// File: rtl/area_csel_pkg.sv
package area_csel_pkg;
  typedef enum logic {
    SEL_DIR = 1'b0,
    SEL_CTL = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/area_csel_decode.sv
module area_csel_decode #(
  parameter int ADDR_W    = 24,
  parameter int NUM_AREAS = 8,
  parameter int AREA_LSB  = 21
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_exp,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_as,
  input  logic                 bus_onchip,
  output logic [NUM_AREAS-1:0] cs_n
);
  localparam int SEL_W = $clog2(NUM_AREAS);

  logic [SEL_W-1:0]     area_idx;
  logic                 ext_access;
  logic [NUM_AREAS-1:0] hit;

  assign area_idx   = bus_addr[AREA_LSB +: SEL_W];
  assign ext_access = mode_exp && bus_as && !bus_onchip;

  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
    assign hit[g] = ext_access && (area_idx == SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) cs_n <= '1;
    else     cs_n <= ~hit;
  end

  p_single_select_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) <= 1);

  p_onchip_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_as && bus_onchip) |=> (cs_n == '1));

  p_single_chip_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !mode_exp |=> (cs_n == '1));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !bus_as |=> (cs_n == '1));
endmodule

// File: rtl/area_csel_regs.sv
module area_csel_regs
  import area_csel_pkg::*;
#(
  parameter int NUM_AREAS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rom_en,
  input  logic                   reg_we,
  input  logic                   reg_sel,
  input  logic [NUM_AREAS/2-1:0] reg_wdata,
  output logic [NUM_AREAS/2-1:0] reg_rdata,
  output logic [NUM_AREAS-1:0]   cs_oe
);
  localparam int HALF = NUM_AREAS / 2;

  reg_sel_e        sel;
  logic [HALF-1:0] dir_q;
  logic [HALF-1:0] ctl_q;
  logic [HALF-1:0] dir_rst;

  assign sel     = reg_sel_e'(reg_sel);
  assign dir_rst = {{(HALF-1){1'b0}}, !rom_en};

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= dir_rst;
      ctl_q <= '0;
    end else if (reg_we) begin
      if (sel == SEL_DIR) dir_q <= reg_wdata;
      else                ctl_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= (sel == SEL_CTL) ? ctl_q : dir_q;
  end

  assign cs_oe = {ctl_q, dir_q};

  p_dir_write_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !reg_sel) |=> (cs_oe[HALF-1:0] == $past(reg_wdata)));

  p_ctl_write_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel) |=> (cs_oe[NUM_AREAS-1:HALF] == $past(reg_wdata)));

  p_oe_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!reg_we && !$past(rst)) |=> $stable(cs_oe));
endmodule

// File: rtl/area_csel_top.sv
module area_csel_top #(
  parameter int ADDR_W    = 24,
  parameter int NUM_AREAS = 8,
  parameter int AREA_LSB  = 21
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   mode_exp,
  input  logic                   rom_en,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_as,
  input  logic                   bus_onchip,
  input  logic                   reg_we,
  input  logic                   reg_sel,
  input  logic [NUM_AREAS/2-1:0] reg_wdata,
  output logic [NUM_AREAS/2-1:0] reg_rdata,
  output logic [NUM_AREAS-1:0]   cs_n,
  output logic [NUM_AREAS-1:0]   cs_oe
);
  area_csel_decode #(
    .ADDR_W(ADDR_W), .NUM_AREAS(NUM_AREAS), .AREA_LSB(AREA_LSB)
  ) u_decode (
    .clk(clk), .rst(rst), .mode_exp(mode_exp), .bus_addr(bus_addr),
    .bus_as(bus_as), .bus_onchip(bus_onchip), .cs_n(cs_n)
  );

  area_csel_regs #(.NUM_AREAS(NUM_AREAS)) u_regs (
    .clk(clk), .rst(rst), .rom_en(rom_en), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cs_oe(cs_oe)
  );

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (cs_n == '1));
endmodule

// File: tb/area_csel_top_tb.sv
module area_csel_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_exp = 1'b1;
  logic        rom_en = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        bus_as = 1'b0;
  logic        bus_onchip = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [3:0]  reg_wdata = '0;
  logic [3:0]  reg_rdata;
  logic [7:0]  cs_n;
  logic [7:0]  cs_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  area_csel_top u_dut (
    .clk(clk), .rst(rst), .mode_exp(mode_exp), .rom_en(rom_en),
    .bus_addr(bus_addr), .bus_as(bus_as), .bus_onchip(bus_onchip),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cs_n(cs_n), .cs_oe(cs_oe)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 50000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset(input logic rom);
    @(negedge clk);
    rst = 1'b1; rom_en = rom; reg_we = 1'b0; bus_as = 1'b0; reg_sel = 1'b0;
    step();
    chk("R1 cs_n in reset", cs_n, 8'hFF);
    @(negedge clk); rst = 1'b0;
    step();
    chk("R1 cs_n after reset", cs_n, 8'hFF);
    chk("R9 cs_oe reset default", cs_oe, rom ? 8'h00 : 8'h01);
  endtask

  task automatic access(input logic exp_mode, input logic onchip,
                        input logic strobe, input logic [2:0] area,
                        input logic [20:0] low, output logic [7:0] got);
    @(negedge clk);
    mode_exp = exp_mode; bus_onchip = onchip; bus_as = strobe;
    bus_addr = {area, low};
    step();
    got = cs_n;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_as = 1'b0; bus_onchip = 1'b0; mode_exp = 1'b1;
  endtask

  task automatic wr(input logic sel, input logic [3:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic test_reset_r1_r9();
    do_reset(1'b1);
    step();
    chk("R1 reg_rdata after reset", {4'h0, reg_rdata}, 8'h00);
    do_reset(1'b0);
    step();
    chk("R10 reg_rdata dir default", {4'h0, reg_rdata}, 8'h01);
  endtask

  task automatic test_areas_r2_r3();
    logic [7:0] got;
    for (int a = 0; a < 8; a++) begin
      access(1'b1, 1'b0, 1'b1, 3'(a), 21'(a * 37'h1F2A3 + 5), got);
      chk($sformatf("R2 area %0d", a), got, ~(8'h01 << a));
      checks = checks + 1;
      if ($countones(~got) > 1) begin
        errors = errors + 1;
        $display("FAIL R3 more than one low: actual %h expected one-hot low", got);
      end
    end
    access(1'b1, 1'b0, 1'b1, 3'd7, 21'h1FFFFF, got);
    chk("R2 top of area 7", got, 8'h7F);
    access(1'b1, 1'b0, 1'b1, 3'd0, 21'h000000, got);
    chk("R2 base of area 0", got, 8'hFE);
    idle(); step();
    chk("R6 deassert after strobe ends", cs_n, 8'hFF);
  endtask

  task automatic test_suppress_r4_r5_r6();
    logic [7:0] got;
    access(1'b1, 1'b1, 1'b1, 3'd3, 21'h00100, got);
    chk("R4 on-chip access", got, 8'hFF);
    access(1'b0, 1'b0, 1'b1, 3'd5, 21'h12345, got);
    chk("R5 single-chip mode", got, 8'hFF);
    access(1'b1, 1'b0, 1'b0, 3'd6, 21'h0ABCD, got);
    chk("R6 no strobe", got, 8'hFF);
    access(1'b1, 1'b0, 1'b1, 3'd6, 21'h0ABCD, got);
    chk("R2 same address with strobe", got, 8'hBF);
    idle(); step();
  endtask

  task automatic test_regs_r7_r8_r10();
    wr(1'b0, 4'hA);
    chk("R7 dir write 1010", cs_oe, 8'h0A);
    wr(1'b1, 4'h5);
    chk("R8 ctl write 0101", cs_oe, 8'h5A);
    wr(1'b0, 4'h5);
    wr(1'b1, 4'hA);
    chk("R8 inverse patterns", cs_oe, 8'hA5);
    @(negedge clk); reg_sel = 1'b0; step(); step();
    chk("R10 read dir", {4'h0, reg_rdata}, 8'h05);
    @(negedge clk); reg_sel = 1'b1; step();
    chk("R10 read ctl", {4'h0, reg_rdata}, 8'h0A);
  endtask

  task automatic test_independent_r11();
    logic [7:0] got;
    wr(1'b0, 4'h0);
    wr(1'b1, 4'h0);
    access(1'b1, 1'b0, 1'b1, 3'd4, 21'h00042, got);
    chk("R11 decode with enables off", got, 8'hEF);
    chk("R11 enables untouched by access", cs_oe, 8'h00);
    idle(); step(); step();
    chk("R11 enables hold without write", cs_oe, 8'h00);
  endtask

  initial begin
    test_reset_r1_r9();
    test_areas_r2_r3();
    test_suppress_r4_r5_r6();
    test_regs_r7_r8_r10();
    test_independent_r11();
    do_reset(1'b0);
    chk("R8 ctl cleared by reset", {4'h0, cs_oe[7:4]}, 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule